// File: doc/BRIEF.md
# Event Performance Counter Bank

A bank of six 32-bit event counters, each read and written through one register port. Each counter picks one line from a wide vector of single-cycle event pulses and adds one on every clock where that line pulses and nothing holds it frozen. Several freeze conditions stack:
- a global freeze bit;
- a hardware freeze that engages once any condition-enabled counter overflows;
- per-counter freezes for user mode, for supervisor mode, and for the processor mark input being high.

A counter counts as overflowed as soon as its top bit is 1, not when it wraps. Software can therefore preload 0x80000000 minus the remaining period and receive a level interrupt when that period has elapsed. The mark input is held high during interrupt service, so counters that are set to freeze on mark stop counting while the handler runs.

Address map: `addr_i[4:3]` selects the register kind and `addr_i[2:0]` selects the counter.

| `addr_i[4:3]` | Register |
|---|---|
| 0 | Counter value |
| 1 | Control A |
| 2 | Control B |
| 3 | Global control (index bits ignored) |

Read data is combinational from the current state. Writes take effect at the clock edge.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter, control A and control B register reads zero, global control reads 0x80000000 (freeze-all set) and `irq_o` is low.
- R2: Counter, control A and control B registers of index 0..5 read back the full 32-bit value last written; indexes 6 and 7 read zero and writes to them change nothing; global control stores bits 31:29 only, other bits read zero.
- R3: The event select is control A bits 23:16. With no freeze active, a counter increases by exactly one in the edge that samples a pulse on `event_i[select]`, and never changes when the select is 0.
- R4: While global control bit 31 (freeze-all) is 1, no counter changes except by a register write.
- R5: Control A bit 29 stops counting while `user_i` is 1; control A bit 28 stops counting while `user_i` is 0.
- R6: Control A bit 27 stops counting while `mark_i` is 1.
- R7: `irq_o` is 1 exactly when global control bit 30 is 1 and some counter has both control A bit 31 and its own bit 31 set; it stays high until the counter is rewritten with bit 31 clear or bit 30 is cleared.
- R8: With global control bit 29 set, once a counter with control A bit 31 has bit 31 set, no counter counts, and freeze-all reads 1 from the next cycle on.
- R9: A register write to a counter in the same cycle as a qualifying event loads the written value, with no added increment.
- R10: Writing global control with only bit 31 set leaves interrupt enable and freeze-on-condition cleared.
- R11: Counters pass through 0x80000000 and keep counting when freeze-on-condition is clear, and wrap from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address: kind in [4:3], counter index in [2:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| event_i | input | 256 | Event pulse vector, bit 0 unused |
| user_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| mark_i | input | 1 | Processor mark bit |
| irq_o | output | 1 | Performance interrupt, level |

## Verification
A wrong counter value shows on `rdata_o` the first time that counter is addressed. It can also show on `irq_o` in the very cycle that its top bit disagrees. The bench addresses one register every cycle, including during bursts of random events. A bad freeze or event-select decode therefore shows up within a few cycles as a count that is off by one or more. A stale freeze-all or interrupt-enable bit shows at once on `irq_o`, or on the next read of global control.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_CNT = 6;
  localparam int NUM_EVT = 256;
  localparam int SEL_W   = $clog2(NUM_EVT);
  localparam int IDX_W   = 3;
  localparam int ADDR_W  = IDX_W + 2;

  // global control bits
  localparam int G_FA = 31;
  localparam int G_IE = 30;
  localparam int G_FC = 29;

  // local control A bits
  localparam int A_CE     = 31;
  localparam int A_FU     = 29;
  localparam int A_FS     = 28;
  localparam int A_FM     = 27;
  localparam int A_SEL_LO = 16;

  typedef enum logic [1:0] {
    RK_CNT  = 2'd0,
    RK_CTLA = 2'd1,
    RK_CTLB = 2'd2,
    RK_GLB  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int NEV = NUM_EVT,
  parameter int SW  = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_we_i,
  input  logic          a_we_i,
  input  logic          b_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NEV-1:0] event_i,
  input  logic          user_i,
  input  logic          mark_i,
  input  logic          gfreeze_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] ctla_o,
  output logic [DW-1:0] ctlb_o,
  output logic          ovf_en_o
);
  logic [DW-1:0] cnt_q, ctla_q, ctlb_q;
  logic [SW-1:0] sel;
  logic          local_frz, hit, inc;

  assign sel       = ctla_q[A_SEL_LO +: SW];
  assign local_frz = (ctla_q[A_FU] & user_i) | (ctla_q[A_FS] & ~user_i) |
                     (ctla_q[A_FM] & mark_i);
  assign hit       = (sel != '0) & event_i[sel];
  assign inc       = hit & ~local_frz & ~gfreeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ctla_q <= '0;
      ctlb_q <= '0;
    end else begin
      if (cnt_we_i)  cnt_q <= wdata_i;  // write wins over increment
      else if (inc)  cnt_q <= cnt_q + DW'(1);
      if (a_we_i)    ctla_q <= wdata_i;
      if (b_we_i)    ctlb_q <= wdata_i;
    end
  end

  assign cnt_o    = cnt_q;
  assign ctla_o   = ctla_q;
  assign ctlb_o   = ctlb_q;
  assign ovf_en_o = ctla_q[A_CE] & cnt_q[DW-1];

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + DW'(1)));
  p_sel0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctla_q[A_SEL_LO +: SW] == '0) && !cnt_we_i |=> $stable(cnt_q));
  p_gfrz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gfreeze_i && !cnt_we_i |=> $stable(cnt_q));
  p_user_frz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctla_q[A_FU] && user_i && !cnt_we_i |=> $stable(cnt_q));
  p_sup_frz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctla_q[A_FS] && !user_i && !cnt_we_i |=> $stable(cnt_q));
  p_mark_frz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctla_q[A_FM] && mark_i && !cnt_we_i |=> $stable(cnt_q));
  p_wr_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/pcb_global.sv
module pcb_global
  import pcb_pkg::*;
#(
  parameter int NC = NUM_CNT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    wctl_i,   // {freeze_all, irq_en, freeze_on_cond}
  input  logic [NC-1:0] ovf_vec_i,
  output logic [2:0]    gctl_o,
  output logic          freeze_o,
  output logic          irq_o
);
  logic fa_q, ie_q, fc_q, any_ovf;

  assign any_ovf = |ovf_vec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fa_q <= 1'b1;
      ie_q <= 1'b0;
      fc_q <= 1'b0;
    end else if (we_i) begin
      {fa_q, ie_q, fc_q} <= wctl_i;
    end else if (fc_q && any_ovf) begin
      fa_q <= 1'b1;  // latch the condition freeze
    end
  end

  // condition freeze acts in the same cycle, before the latch lands
  assign freeze_o = fa_q | (fc_q & any_ovf);
  assign irq_o    = ie_q & any_ovf;
  assign gctl_o   = {fa_q, ie_q, fc_q};

  p_fc_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_q && any_ovf && !we_i |=> fa_q);
  p_fa_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (wctl_i == 3'b100) |=> fa_q && !ie_q && !fc_q);
  p_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !wctl_i[1] |=> !irq_o);
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int NC  = NUM_CNT,
  parameter int NEV = NUM_EVT,
  parameter int IW  = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW+1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NEV-1:0] event_i,
  input  logic          user_i,
  input  logic          mark_i,
  output logic          irq_o
);
  localparam int SW = $clog2(NEV);

  reg_kind_e     kind;
  logic [IW-1:0] idx;
  logic          idx_ok;
  logic [DW-1:0] cnt_arr  [NC];
  logic [DW-1:0] ctla_arr [NC];
  logic [DW-1:0] ctlb_arr [NC];
  logic [NC-1:0] ovf_vec;
  logic [2:0]    gctl;
  logic          gfreeze;

  assign kind   = reg_kind_e'(addr_i[IW+1:IW]);
  assign idx    = addr_i[IW-1:0];
  assign idx_ok = int'(idx) < NC;

  pcb_global #(.NC(NC)) u_global (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i && kind == RK_GLB),
    .wctl_i    (wdata_i[DW-1 -: 3]),
    .ovf_vec_i (ovf_vec),
    .gctl_o    (gctl),
    .freeze_o  (gfreeze),
    .irq_o     (irq_o)
  );

  for (genvar i = 0; i < NC; i++) begin : g_cnt
    logic sel_me;
    assign sel_me = we_i && (int'(idx) == i);
    pcb_counter #(.DW(DW), .NEV(NEV), .SW(SW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_we_i  (sel_me && kind == RK_CNT),
      .a_we_i    (sel_me && kind == RK_CTLA),
      .b_we_i    (sel_me && kind == RK_CTLB),
      .wdata_i   (wdata_i),
      .event_i   (event_i),
      .user_i    (user_i),
      .mark_i    (mark_i),
      .gfreeze_i (gfreeze),
      .cnt_o     (cnt_arr[i]),
      .ctla_o    (ctla_arr[i]),
      .ctlb_o    (ctlb_arr[i]),
      .ovf_en_o  (ovf_vec[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (kind)
      RK_GLB:  rdata_o[DW-1 -: 3] = gctl;
      RK_CNT:  if (idx_ok) rdata_o = cnt_arr[idx];
      RK_CTLA: if (idx_ok) rdata_o = ctla_arr[idx];
      RK_CTLB: if (idx_ok) rdata_o = ctlb_arr[idx];
      default: rdata_o = '0;
    endcase
  end

  p_rd_hole_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind != RK_GLB) && !idx_ok |-> rdata_o == '0);
  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gctl[1] && (ovf_vec != '0));
  p_frozen_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gctl[0] && (ovf_vec != '0) && !we_i |=> gctl[2]);
endmodule

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
module perf_counter_bank_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [4:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [255:0] ev = '0;
  logic         usr = 1'b0;
  logic         mk = 1'b0;
  logic         irq;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_cnt [6];
  logic [31:0] m_a   [6];
  logic [31:0] m_b   [6];
  logic [31:0] m_g;

  always #2 clk = ~clk;  // 250 MHz

  perf_counter_bank u_perf_counter_bank (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .event_i(ev), .user_i(usr), .mark_i(mk), .irq_o(irq)
  );

  function automatic logic m_any_ovf();
    logic r = 1'b0;
    for (int i = 0; i < 6; i++) r |= m_a[i][31] & m_cnt[i][31];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    int k = int'(a[4:3]);
    int n = int'(a[2:0]);
    if (k == 3) return m_g & 32'hE000_0000;
    if (n > 5) return 32'h0;
    if (k == 0) return m_cnt[n];
    if (k == 1) return m_a[n];
    return m_b[n];
  endfunction

  function automatic logic [255:0] bit_at(input int n);
    logic [255:0] v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 6; i++) begin
      m_cnt[i] = '0; m_a[i] = '0; m_b[i] = '0;
    end
    m_g = 32'h8000_0000;
  endtask

  task automatic m_step(input logic w, input logic [4:0] a, input logic [31:0] d,
                        input logic [255:0] e, input logic u, input logic m);
    logic ovf = m_any_ovf();
    logic gf  = m_g[31] | (m_g[29] & ovf);
    int   k   = int'(a[4:3]);
    int   n   = int'(a[2:0]);
    for (int i = 0; i < 6; i++) begin
      int  sel = int'(m_a[i][23:16]);
      logic lf = (m_a[i][29] & u) | (m_a[i][28] & ~u) | (m_a[i][27] & m);
      if (w && k == 0 && n == i) m_cnt[i] = d;
      else if (!gf && sel != 0 && e[sel] && !lf) m_cnt[i] = m_cnt[i] + 32'd1;
      if (w && k == 1 && n == i) m_a[i] = d;
      if (w && k == 2 && n == i) m_b[i] = d;
    end
    if (w && k == 3) m_g = d & 32'hE000_0000;
    else if (m_g[29] && ovf) m_g[31] = 1'b1;
  endtask

  // one clock: drive, check read data and irq before the edge, advance model
  task automatic cyc(input string tag, input logic w, input logic [4:0] a,
                     input logic [31:0] d, input logic [255:0] e,
                     input logic u = 1'b0, input logic m = 1'b0);
    logic [31:0] exp_rd;
    logic        exp_irq;
    @(negedge clk);
    we = w; addr = a; wdata = d; ev = e; usr = u; mk = m;
    #1;
    exp_rd  = m_read(a);
    exp_irq = m_g[30] & m_any_ovf();
    checks++;
    if (rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s addr=%0d rdata actual=%h expected=%h", tag, a, rdata, exp_rd);
    end
    checks++;
    if (irq !== exp_irq) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
    end
    @(posedge clk);
    m_step(w, a, d, e, u, m);
  endtask

  task automatic rd(input string tag, input logic [4:0] a);
    cyc(tag, 1'b0, a, 32'h0, '0);
  endtask

  task automatic wr(input string tag, input logic [4:0] a, input logic [31:0] d);
    cyc(tag, 1'b1, a, d, '0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 holes at index 6 and 7
    for (int a = 0; a < 32; a++) rd("R1", 5'(a));

    // R3 basic counting on select 5
    wr("R3", 5'd24, 32'h0);
    wr("R3", 5'd8,  32'h0005_0000);
    repeat (3) cyc("R3", 1'b0, 5'd0, 32'h0, bit_at(5));
    rd("R3", 5'd0);
    // R3 select 0 never counts
    repeat (2) cyc("R3", 1'b0, 5'd1, 32'h0, bit_at(0) | bit_at(5));
    rd("R3", 5'd1);

    // R9 write beats increment
    cyc("R9", 1'b1, 5'd0, 32'd100, bit_at(5));
    rd("R9", 5'd0);

    // R5 privilege freezes
    wr("R5", 5'd8, 32'h2005_0000);
    cyc("R5", 1'b0, 5'd0, 32'h0, bit_at(5), 1'b1);
    cyc("R5", 1'b0, 5'd0, 32'h0, bit_at(5), 1'b0);
    wr("R5", 5'd8, 32'h1005_0000);
    cyc("R5", 1'b0, 5'd0, 32'h0, bit_at(5), 1'b0);
    cyc("R5", 1'b0, 5'd0, 32'h0, bit_at(5), 1'b1);
    rd("R5", 5'd0);

    // R6 mark freeze
    wr("R6", 5'd8, 32'h0805_0000);
    cyc("R6", 1'b0, 5'd0, 32'h0, bit_at(5), 1'b0, 1'b1);
    cyc("R6", 1'b0, 5'd0, 32'h0, bit_at(5), 1'b0, 1'b0);
    rd("R6", 5'd0);

    // R11 wrap and pass through the top bit
    wr("R11", 5'd8, 32'h0005_0000);
    wr("R11", 5'd0, 32'hFFFF_FFFF);
    cyc("R11", 1'b0, 5'd0, 32'h0, bit_at(5));
    wr("R11", 5'd0, 32'h7FFF_FFFF);
    cyc("R11", 1'b0, 5'd0, 32'h0, bit_at(5));
    cyc("R11", 1'b0, 5'd0, 32'h0, bit_at(5));
    rd("R11", 5'd0);

    // R7 level interrupt
    wr("R7", 5'd8, 32'h8005_0000);
    wr("R7", 5'd24, 32'h4000_0000);
    repeat (3) rd("R7", 5'd0);
    wr("R7", 5'd0, 32'd5);
    rd("R7", 5'd0);

    // R8 freeze on condition
    wr("R8", 5'd24, 32'h6000_0000);
    wr("R8", 5'd0, 32'h7FFF_FFFF);
    wr("R8", 5'd9, 32'h0006_0000);
    cyc("R8", 1'b0, 5'd0, 32'h0, bit_at(5) | bit_at(6));
    cyc("R8", 1'b0, 5'd1, 32'h0, bit_at(5) | bit_at(6));
    cyc("R8", 1'b0, 5'd24, 32'h0, bit_at(5) | bit_at(6));
    rd("R8", 5'd0);
    rd("R8", 5'd1);

    // R10 freeze-all alone clears the other bits
    wr("R10", 5'd24, 32'h8000_0000);
    rd("R10", 5'd24);
    // R4 freeze-all blocks counting
    wr("R4", 5'd0, 32'd7);
    cyc("R4", 1'b0, 5'd0, 32'h0, bit_at(5) | bit_at(6));
    rd("R4", 5'd0);
    rd("R4", 5'd1);

    // random mix
    for (int it = 0; it < 4000; it++) begin
      logic [4:0]   a  = 5'($urandom);
      logic         w  = ($urandom % 4) == 0;
      logic [31:0]  d  = $urandom;
      logic [255:0] e;
      int           sels[5] = '{1, 2, 3, 255, 0};
      for (int j = 0; j < 8; j++) e[j*32 +: 32] = $urandom;
      if (a[4:3] == 2'd1) d[23:16] = 8'(sels[$urandom % 5]);
      if (a[4:3] == 2'd0 && ($urandom % 2) == 0)
        d = (($urandom % 2) == 0) ? 32'h7FFF_FFF0 : 32'hFFFF_FFF8;
      if (a[4:3] == 2'd3 && ($urandom % 4) != 0) d[31] = 1'b0;
      cyc("R2", w, a, d, e, 1'($urandom), 1'(($urandom % 8) == 0));
    end
    for (int a = 0; a < 32; a++) rd("R2", 5'(a));

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule